// File: doc/BRIEF.md
# Producer-Tracking Rename Map

This block is the register rename table of an out-of-order front end. It holds one entry per logical register. Each entry stores the tag (sequence number) of the in-flight instruction that last wrote that register, plus a bit that says whether that producer's result already exists. For each instruction it renames, the block looks up up to two source registers. It reports the producer tag of each source and whether that source is ready. It also returns the tag that the destination register held before the rename, so that recovery logic can keep it. Then it installs the new instruction's tag as the destination's producer.

A writeback port carries the tag of a finished instruction. Every entry mapped to that tag becomes ready, and a source looked up in the same cycle sees the writeback at once. A commit port keeps a second copy of the table in program order. A squash throws away all speculative mappings by loading the whole table from that committed copy. After a squash every entry is ready, because committed values are architectural state.

Top module: `rename_map_table`

## Requirements
- R1: After reset `res_valid` is 0, and every logical register maps to tag 0 and is ready, in both the speculative table and the committed copy.
- R2: One cycle after a rename (`ren_valid`=1, `sq_valid`=0), `res_valid` is 1. Each valid source reports the tag in its table entry and that entry's ready bit. When `ren_valid` is 0, `res_valid` is 0 in the next cycle.
- R3: A source whose valid bit is 0 is not looked up. It reports tag 0 and ready=1.
- R4: `res_prev_tag` is the destination's tag before this rename. Sources read the mapping from before the install, even when a source index equals the destination index.
- R5: After a rename with a valid destination, that entry holds `ren_tag` and is not ready. The exception is a writeback in the same cycle carrying `ren_tag`: then the entry is ready.
- R6: A writeback marks ready every entry whose tag equals `wb_tag`, including several entries that share one tag.
- R7: A writeback in the same cycle as a lookup, whose tag equals a source's mapped tag, makes that source report ready.
- R8: A commit writes `cm_tag` into the committed copy at `cm_idx`. A squash loads every entry from the committed copy and marks all entries ready.
- R9: A rename and a writeback in a squash cycle have no effect. `res_valid` is 0 in the next cycle, and the table afterwards equals the committed copy.
- R10: A commit in the same cycle as a squash is included in the restored table.
- R11: A rename without a valid destination reports `res_prev_tag` = 0 and changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ren_valid | input | 1 | Rename request this cycle |
| ren_tag | input | TAG_W | Tag of the instruction being renamed |
| ren_s0_vld | input | 1 | First source present |
| ren_s0_idx | input | IDX_W | First source logical register |
| ren_s1_vld | input | 1 | Second source present |
| ren_s1_idx | input | IDX_W | Second source logical register |
| ren_dst_vld | input | 1 | Destination present |
| ren_dst_idx | input | IDX_W | Destination logical register |
| wb_valid | input | 1 | Writeback broadcast |
| wb_tag | input | TAG_W | Tag of the finished producer |
| cm_valid | input | 1 | Commit of one destination |
| cm_idx | input | IDX_W | Committed logical register |
| cm_tag | input | TAG_W | Committed producer tag |
| sq_valid | input | 1 | Squash: restore from the committed copy |
| res_valid | output | 1 | Rename result valid |
| res_s0_tag | output | TAG_W | First source producer tag |
| res_s0_rdy | output | 1 | First source ready |
| res_s1_tag | output | TAG_W | Second source producer tag |
| res_s1_rdy | output | 1 | Second source ready |
| res_prev_tag | output | TAG_W | Previous producer of the destination |

## Verification
- **Result timing.** Rename results are registered and appear one clock after the cycle in which the request is presented.
- **State-update timing.** Table updates from a rename, writeback, commit or squash take effect at the same edge. A lookup in the next cycle sees them, and its result appears one cycle after that.
- **Reference model.** The bench drives inputs on the falling edge. Before the rising edge it computes the expected result from a model of the table in its pre-edge state, and it updates the model at the same edge as the design.
- **Sampling.** It compares the outputs at the following falling edge, which is exactly one register stage later.
- **Effects seen only through later renames.** Properties that change only the table, such as squash restore and ignored renames, are checked by later lookups of the affected registers.

// File: rtl/rename_map_table.sv
module rename_map_table #(
  parameter int NUM_LREG = 32,
  parameter int TAG_W = 8,
  localparam int IDX_W = $clog2(NUM_LREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ren_valid,
  input  logic [TAG_W-1:0] ren_tag,
  input  logic             ren_s0_vld,
  input  logic [IDX_W-1:0] ren_s0_idx,
  input  logic             ren_s1_vld,
  input  logic [IDX_W-1:0] ren_s1_idx,
  input  logic             ren_dst_vld,
  input  logic [IDX_W-1:0] ren_dst_idx,
  input  logic             wb_valid,
  input  logic [TAG_W-1:0] wb_tag,
  input  logic             cm_valid,
  input  logic [IDX_W-1:0] cm_idx,
  input  logic [TAG_W-1:0] cm_tag,
  input  logic             sq_valid,
  output logic             res_valid,
  output logic [TAG_W-1:0] res_s0_tag,
  output logic             res_s0_rdy,
  output logic [TAG_W-1:0] res_s1_tag,
  output logic             res_s1_rdy,
  output logic [TAG_W-1:0] res_prev_tag
);

  logic [TAG_W-1:0]    map_tag [NUM_LREG];
  logic [NUM_LREG-1:0] map_rdy;
  logic [TAG_W-1:0]    arch_tag [NUM_LREG];

  logic [TAG_W-1:0] s0_map, s1_map, dst_map;
  logic             s0_hot, s1_hot;
  logic             do_ren, do_ins;

  assign s0_map  = map_tag[ren_s0_idx];
  assign s1_map  = map_tag[ren_s1_idx];
  assign dst_map = map_tag[ren_dst_idx];
  assign s0_hot  = map_rdy[ren_s0_idx] || (wb_valid && wb_tag == s0_map);
  assign s1_hot  = map_rdy[ren_s1_idx] || (wb_valid && wb_tag == s1_map);
  assign do_ren  = ren_valid && !sq_valid;
  assign do_ins  = do_ren && ren_dst_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_LREG; i++) begin
        map_tag[i]  <= '0;
        map_rdy[i]  <= 1'b1;
        arch_tag[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_LREG; i++) begin
        if (cm_valid && cm_idx == IDX_W'(i))
          arch_tag[i] <= cm_tag;
        if (sq_valid) begin
          map_tag[i] <= (cm_valid && cm_idx == IDX_W'(i)) ? cm_tag : arch_tag[i];
          map_rdy[i] <= 1'b1;
        end else if (do_ins && ren_dst_idx == IDX_W'(i)) begin
          map_tag[i] <= ren_tag;
          map_rdy[i] <= wb_valid && wb_tag == ren_tag;
        end else if (wb_valid && wb_tag == map_tag[i]) begin
          map_rdy[i] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      res_s0_tag   <= '0;
      res_s0_rdy   <= 1'b0;
      res_s1_tag   <= '0;
      res_s1_rdy   <= 1'b0;
      res_prev_tag <= '0;
    end else begin
      res_valid    <= do_ren;
      res_s0_tag   <= ren_s0_vld ? s0_map : '0;
      res_s0_rdy   <= !ren_s0_vld || s0_hot;
      res_s1_tag   <= ren_s1_vld ? s1_map : '0;
      res_s1_rdy   <= !ren_s1_vld || s1_hot;
      res_prev_tag <= ren_dst_vld ? dst_map : '0;
    end
  end

endmodule

// File: rtl/rename_map_table_chk.sv
module rename_map_table_chk #(
  parameter int TAG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ren_valid,
  input logic             ren_s0_vld,
  input logic             ren_dst_vld,
  input logic             sq_valid,
  input logic             res_valid,
  input logic [TAG_W-1:0] res_s0_tag,
  input logic             res_s0_rdy,
  input logic [TAG_W-1:0] res_prev_tag
);

  assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |=> !res_valid);

  assert_result_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ren_valid && !sq_valid |=> res_valid);

  assert_idle_no_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ren_valid |=> !res_valid);

  assert_absent_src_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ren_valid && !sq_valid && !ren_s0_vld |=> res_s0_rdy && res_s0_tag == '0);

  assert_squash_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sq_valid |=> !res_valid);

  assert_no_dst_prev_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ren_valid && !sq_valid && !ren_dst_vld |=> res_prev_tag == '0);

endmodule

bind rename_map_table rename_map_table_chk #(.TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_s0_vld(ren_s0_vld),
  .ren_dst_vld(ren_dst_vld), .sq_valid(sq_valid), .res_valid(res_valid),
  .res_s0_tag(res_s0_tag), .res_s0_rdy(res_s0_rdy), .res_prev_tag(res_prev_tag)
);

// File: tb/sim_rename_map_table.sv
`timescale 1ns/1ps
module sim_rename_map_table;
  localparam int NL = 32;
  localparam int TW = 8;
  localparam int IW = $clog2(NL);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ren_valid, ren_s0_vld, ren_s1_vld, ren_dst_vld, wb_valid, cm_valid, sq_valid;
  logic [TW-1:0] ren_tag, wb_tag, cm_tag;
  logic [IW-1:0] ren_s0_idx, ren_s1_idx, ren_dst_idx, cm_idx;
  logic res_valid, res_s0_rdy, res_s1_rdy;
  logic [TW-1:0] res_s0_tag, res_s1_tag, res_prev_tag;

  rename_map_table #(.NUM_LREG(NL), .TAG_W(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_tag(ren_tag),
    .ren_s0_vld(ren_s0_vld), .ren_s0_idx(ren_s0_idx), .ren_s1_vld(ren_s1_vld),
    .ren_s1_idx(ren_s1_idx), .ren_dst_vld(ren_dst_vld), .ren_dst_idx(ren_dst_idx),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .cm_valid(cm_valid), .cm_idx(cm_idx),
    .cm_tag(cm_tag), .sq_valid(sq_valid), .res_valid(res_valid),
    .res_s0_tag(res_s0_tag), .res_s0_rdy(res_s0_rdy), .res_s1_tag(res_s1_tag),
    .res_s1_rdy(res_s1_rdy), .res_prev_tag(res_prev_tag)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  int m_tag [NL];
  bit m_rdy [NL];
  int m_cm [NL];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic bit src_rdy(input int idx);
    return m_rdy[idx] || (wb_valid && int'(wb_tag) == m_tag[idx]);
  endfunction

  task automatic idle();
    ren_valid = 0; ren_tag = '0; ren_s0_vld = 0; ren_s0_idx = '0;
    ren_s1_vld = 0; ren_s1_idx = '0; ren_dst_vld = 0; ren_dst_idx = '0;
    wb_valid = 0; wb_tag = '0; cm_valid = 0; cm_idx = '0; cm_tag = '0; sq_valid = 0;
  endtask

  task automatic ren(input bit s0v, input int s0, input bit s1v, input int s1,
                     input bit dv, input int d, input int tag);
    ren_valid = 1; ren_s0_vld = s0v; ren_s0_idx = IW'(s0); ren_s1_vld = s1v;
    ren_s1_idx = IW'(s1); ren_dst_vld = dv; ren_dst_idx = IW'(d); ren_tag = TW'(tag);
  endtask

  task automatic tick(input string req);
    bit ev, e0r, e1r;
    int e0t, e1t, ep;
    ev  = ren_valid && !sq_valid;
    e0t = ren_s0_vld ? m_tag[ren_s0_idx] : 0;
    e0r = !ren_s0_vld || src_rdy(int'(ren_s0_idx));
    e1t = ren_s1_vld ? m_tag[ren_s1_idx] : 0;
    e1r = !ren_s1_vld || src_rdy(int'(ren_s1_idx));
    ep  = ren_dst_vld ? m_tag[ren_dst_idx] : 0;
    if (cm_valid) m_cm[cm_idx] = int'(cm_tag);
    if (sq_valid) begin
      for (int i = 0; i < NL; i++) begin m_tag[i] = m_cm[i]; m_rdy[i] = 1; end
    end else begin
      if (wb_valid)
        for (int i = 0; i < NL; i++) if (m_tag[i] == int'(wb_tag)) m_rdy[i] = 1;
      if (ren_valid && ren_dst_vld) begin
        m_tag[ren_dst_idx] = int'(ren_tag);
        m_rdy[ren_dst_idx] = wb_valid && wb_tag == ren_tag;
      end
    end
    @(posedge clk);
    @(negedge clk);
    idle();
    chk(res_valid == ev, {req, " valid"}, int'(res_valid), int'(ev));
    if (ev) begin
      chk(int'(res_s0_tag) == e0t, {req, " s0 tag"}, int'(res_s0_tag), e0t);
      chk(res_s0_rdy == e0r, {req, " s0 rdy"}, int'(res_s0_rdy), int'(e0r));
      chk(int'(res_s1_tag) == e1t, {req, " s1 tag"}, int'(res_s1_tag), e1t);
      chk(res_s1_rdy == e1r, {req, " s1 rdy"}, int'(res_s1_rdy), int'(e1r));
      chk(int'(res_prev_tag) == ep, {req, " prev"}, int'(res_prev_tag), ep);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog act=1 exp=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int tcnt;
    int recent [8];
    void'($urandom(32'd4242));
    idle();
    for (int i = 0; i < NL; i++) begin m_tag[i] = 0; m_rdy[i] = 1; m_cm[i] = 0; end
    for (int i = 0; i < 8; i++) recent[i] = 0;
    repeat (3) @(negedge clk);
    chk(res_valid == 0, "R1 reset valid", int'(res_valid), 0);
    rst_n = 1;
    @(negedge clk);
    ren(1, 5, 1, 9, 1, 5, 11);            tick("R1");
    ren(1, 5, 0, 0, 0, 0, 0);             tick("R2 R5");
    ren(1, 5, 1, 5, 1, 5, 12);            tick("R4");
    ren(1, 5, 1, 1, 0, 0, 0); wb_valid = 1; wb_tag = 12; tick("R7");
    ren(0, 0, 0, 0, 1, 3, 20);            tick("R5");
    ren(0, 0, 0, 0, 1, 4, 20);            tick("R5");
    wb_valid = 1; wb_tag = 20;            tick("R6");
    ren(1, 3, 1, 4, 0, 0, 0);             tick("R6");
    ren(0, 0, 0, 0, 0, 9, 33);            tick("R3 R11");
    ren(1, 9, 0, 0, 0, 0, 0);             tick("R11");
    cm_valid = 1; cm_idx = 3; cm_tag = 40; tick("R8");
    ren(0, 0, 0, 0, 1, 7, 50); cm_valid = 1; cm_idx = 6; cm_tag = 41;
    sq_valid = 1; wb_valid = 1; wb_tag = 50; tick("R9 R10");
    ren(1, 3, 1, 6, 1, 7, 51);            tick("R8 R10");
    ren(1, 5, 1, 4, 0, 0, 0);             tick("R8 R9");
    ren(0, 0, 0, 0, 1, 8, 60); wb_valid = 1; wb_tag = 60; tick("R5");
    ren(1, 8, 1, 7, 0, 0, 0);             tick("R5");
    tcnt = 70;
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 99) < 75) begin
        tcnt = (tcnt % 255) + 1;
        ren($urandom_range(0, 9) < 8, int'($urandom_range(0, NL - 1)),
            $urandom_range(0, 9) < 7, int'($urandom_range(0, NL - 1)),
            $urandom_range(0, 9) < 8, int'($urandom_range(0, NL - 1)), tcnt);
        recent[n % 8] = tcnt;
      end
      if ($urandom_range(0, 9) < 4) begin
        wb_valid = 1; wb_tag = TW'(recent[$urandom_range(0, 7)]);
      end
      if ($urandom_range(0, 9) < 3) begin
        cm_valid = 1; cm_idx = IW'($urandom_range(0, NL - 1));
        cm_tag = TW'($urandom_range(0, 255));
      end
      if ($urandom_range(0, 59) == 0) sq_valid = 1;
      tick("R2 random");
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule